// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 and Clause 45)

This block lets host software reach the management registers of external Ethernet PHYs over the two-wire MDC/MDIO bus. Software first programs an address register. It then writes a combined command/data register with the busy bit set, and that write launches a transaction. The engine builds the serial frame and drives MDC, which it derives from the system clock through a selectable divider. It drives MDIO and its output enable, releases the line for the turnaround of a read, and shifts in the 16 bits the PHY returns. When the transaction is over it clears busy, and for a read it leaves the returned value in the low half of the command/data register.

A single engine serves both frame families. A one-hot port-select register chooses Clause 22 framing for a port, and only ports 0 to 3 can be chosen. Every other access uses Clause 45 framing. A Clause 45 access normally sends an address frame first and then the operation frame. A per-transaction skip bit drops the address frame. A read-increment command also advances the stored register address once the read is done.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After an active-low synchronous reset, all three registers read as zero, MDC is low, the MDIO output enable is low and busy is clear.
- R2: Register select 1 is the command/data register: bits 15:0 data, bits 17:16 command, bit 18 skip-address-frame, bits 21:19 divider select, bit 22 busy. Register select 0 is the address register (bits 15:0 register address, bits 20:16 port, bits 25:21 device; bits 4:0 are the Clause 22 register number). Register select 2 is the port-select register, bits 3:0. Writing select 1 with bit 22 set starts a transaction, and bit 22 reads 1 until the transaction ends.
- R3: The MDC period is 4 + 2·D system clocks, where D is the divider select (0 to 7).
- R4: MDIO output and output enable change only after an MDC falling edge and stay stable while MDC is high. Read data is sampled on MDC rising edges.
- R5: A Clause 45 frame is 32 ones, start 00, a 2-bit opcode (00 address, 01 write, 11 read, 10 read-increment), 5-bit port, 5-bit device, turnaround 10 and 16 data bits. Unless skipped, an address frame that carries address bits 15:0 precedes the operation frame.
- R6: With the skip bit set, a Clause 45 access sends only the operation frame.
- R7: If the port is below 4 and its bit in the port-select register is set, a single Clause 22 frame is sent: start 01, opcode 01 for write and 10 for either read command, then port and 5-bit register number.
- R8: A port of 4 or above never produces a Clause 22 frame. Such an access, and any access whose port-select bit is clear, uses Clause 45 framing.
- R9: In a read frame the output enable is low for the two turnaround bits and the 16 data bits. The data bits are captured MSB first, and on completion they appear in command/data bits 15:0. A write leaves bits 15:0 unchanged.
- R10: When a Clause 45 read-increment completes, address bits 15:0 go up by one and wrap from FFFF to 0000.
- R11: While busy is set, writes to any register are ignored and do not restart the transaction.
- R12: A start with command 0 sends no frame, keeps MDC low and clears busy on the second clock edge after the write.
- R13: While idle, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes (0 address, 1 command/data, 2 port select) |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for the read port |
| rd_data | output | 32 | Contents of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high when the master drives |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
A bench-side PHY model records every bit the master drives, together with its enable, on each MDC rising edge. It also returns a chosen 16-bit pattern during read data slots. Directed cases cover each framing path against the bench's own model: Clause 45 with and without the address frame, read versus read-increment (including the FFFF wrap), Clause 22 on a selected port, and ports that fall back to Clause 45 because they are 4 or above or not selected. Further directed cases check writes made during a transaction, which must be ignored, and command 0, which must send no frame. Random transactions mix port, port-select mask, command, skip and divider. The recorded frame count and bits, the MDC period and the returned data then tell apart mistakes in frame choice, opcode, field order, turnaround release and sampling phase.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int PRE_LEN   = 32,
  parameter int C22_PORTS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int FL     = PRE_LEN + 32;
  localparam int BW     = $clog2(FL + 1);
  localparam int PW     = (C22_PORTS > 1) ? $clog2(C22_PORTS) : 1;
  localparam int TA_POS = PRE_LEN + 14;
  localparam int RX_POS = PRE_LEN + 16;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} state_t;

  state_t                 st_q;
  logic [25:0]            addr_q;
  logic [C22_PORTS-1:0]   port_q;
  logic [15:0]            data_q;
  logic [1:0]             cmd_q;
  logic                   skip_q;
  logic [2:0]             div_q;
  logic                   mdc_q;
  logic [FL-1:0]          sh_q;
  logic [BW-1:0]          bit_q;
  logic [3:0]             cnt_q;
  logic                   last_q;
  logic                   rdf_q;
  logic [15:0]            rx_q;

  wire busy = (st_q != S_IDLE);
  wire [4:0] pa = addr_q[20:16];
  wire c22 = ({27'd0, pa} < C22_PORTS) && port_q[pa[PW-1:0]];
  wire is_rd = cmd_q[1];
  wire [1:0] op45 = (cmd_q == 2'd1) ? 2'b01 : (cmd_q == 2'd2) ? 2'b10 : 2'b11;
  wire [17:0] tail = is_rd ? 18'h3ffff : {2'b10, data_q};
  wire [FL-1:0] op_frame = c22
    ? {{PRE_LEN{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), pa, addr_q[4:0], tail}
    : {{PRE_LEN{1'b1}}, 2'b00, op45, pa, addr_q[25:21], tail};
  wire [FL-1:0] adr_frame = {{PRE_LEN{1'b1}}, 4'b0000, pa, addr_q[25:21], 2'b10, addr_q[15:0]};
  wire single = c22 || skip_q;
  wire tick = (cnt_q == ({1'b0, div_q} + 4'd1));
  wire [BW-1:0] bit_last = BW'(FL - 1);
  wire unused_hi = ^wr_data[31:26];

  assign mdc     = mdc_q;
  assign mdio_o  = (st_q == S_SHIFT) ? sh_q[FL-1] : 1'b1;
  assign mdio_oe = (st_q == S_SHIFT) && !(rdf_q && (bit_q >= BW'(TA_POS)));

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {6'd0, addr_q};
      2'd1:    rd_data = {9'd0, busy, div_q, skip_q, cmd_q, data_q};
      2'd2:    rd_data = {{(32-C22_PORTS){1'b0}}, port_q};
      default: rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      port_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
      skip_q <= 1'b0;
      div_q  <= '0;
      mdc_q  <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
      rdf_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (wr_en) begin
            case (wr_sel)
              2'd0: addr_q <= wr_data[25:0];
              2'd1: begin
                data_q <= wr_data[15:0];
                cmd_q  <= wr_data[17:16];
                skip_q <= wr_data[18];
                div_q  <= wr_data[21:19];
                if (wr_data[22]) st_q <= S_LOAD;
              end
              2'd2: port_q <= wr_data[C22_PORTS-1:0];
              default: ;
            endcase
          end
        end
        S_LOAD: begin
          if (cmd_q == 2'd0) begin
            st_q <= S_IDLE;
          end else begin
            sh_q   <= single ? op_frame : adr_frame;
            last_q <= single;
            rdf_q  <= single && is_rd;
            bit_q  <= '0;
            cnt_q  <= '0;
            mdc_q  <= 1'b0;
            rx_q   <= '0;
            st_q   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
            if (!mdc_q) begin
              if (rdf_q && (bit_q >= BW'(RX_POS))) rx_q <= {rx_q[14:0], mdio_i};
            end else if (bit_q == bit_last) begin
              if (last_q) begin
                st_q <= S_IDLE;
                if (is_rd) data_q <= rx_q;
                if (cmd_q == 2'd2 && !c22) addr_q[15:0] <= addr_q[15:0] + 16'd1;
              end else begin
                sh_q   <= op_frame;
                last_q <= 1'b1;
                rdf_q  <= is_rd;
                bit_q  <= '0;
              end
            end else begin
              sh_q  <= {sh_q[FL-2:0], 1'b1};
              bit_q <= bit_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic [25:0] addr_q
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mdc && !mdio_oe && !busy));

  a_r4_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r13_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));

  a_r2_done_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .addr_q(addr_q)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic mdc, mdio_o, mdio_oe;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic rec_o [0:127];
  logic rec_oe [0:127];
  int nrec = 0, since_rise = 0, last_period = 0, r4_viol = 0;
  logic [15:0] phy_val = 16'h0;
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

  always @(posedge clk) since_rise++;
  always @(posedge mdc) begin
    last_period = since_rise;
    since_rise = 0;
    if (nrec < 128) begin
      rec_o[nrec] = mdio_o;
      rec_oe[nrec] = mdio_oe;
    end
    nrec++;
  end
  always @(negedge mdc) begin
    int idx;
    idx = nrec % 64;
    mdio_i = (idx >= 48) ? phy_val[63-idx] : 1'b1;
  end
  always @(negedge clk) begin
    if (rst_n && mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) r4_viol++;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); rd_sel = sel; #1 d = rd_data;
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      reg_rd(2'd1, v);
      if (!v[22]) return;
    end
  endtask

  function automatic logic [63:0] frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] pa, input logic [4:0] ra, input logic [17:0] tl);
    return {32'hffffffff, st, op, pa, ra, tl};
  endfunction

  task automatic cmp_frame(input int base, input logic [63:0] f, input bit rd, input string req);
    int bad = 0;
    logic [63:0] got = '0;
    for (int i = 0; i < 64; i++) begin
      bit eoe;
      eoe = !(rd && i >= 46);
      got[63-i] = rec_o[base+i];
      if (rec_oe[base+i] !== eoe) bad++;
      else if (eoe && rec_o[base+i] !== f[63-i]) bad++;
    end
    chk(bad == 0, req, got, f);
  endtask

  task automatic txn(input logic [25:0] a, input logic [3:0] ports, input logic [1:0] cmd,
      input bit skip, input logic [2:0] dv, input logic [15:0] wd, input logic [15:0] pv,
      input string req);
    logic [31:0] v;
    bit c22, rd;
    int nf;
    logic [1:0] op;
    logic [25:0] a_exp;
    logic [15:0] d_exp;
    reg_wr(2'd2, {28'd0, ports});
    reg_wr(2'd0, {6'd0, a});
    phy_val = pv;
    @(negedge clk); nrec = 0;
    reg_wr(2'd1, {9'd0, 1'b1, dv, skip, cmd, wd});
    wait_idle();
    c22 = (a[20:16] < 5'd4) && ports[a[17:16]];
    rd = cmd[1];
    nf = (c22 || skip) ? 1 : 2;
    chk(nrec == 64*nf, {req, " R5/R6/R7 frame count"}, 64'(nrec), 64'(64*nf));
    if (nf == 2) cmp_frame(0, frame(2'b00, 2'b00, a[20:16], a[25:21], {2'b10, a[15:0]}), 1'b0, {req, " R5 address frame"});
    if (c22) op = rd ? 2'b10 : 2'b01;
    else op = (cmd == 2'd1) ? 2'b01 : (cmd == 2'd2) ? 2'b10 : 2'b11;
    cmp_frame(64*(nf-1), frame(c22 ? 2'b01 : 2'b00, op, a[20:16], c22 ? a[4:0] : a[25:21],
              rd ? 18'h3ffff : {2'b10, wd}), rd, {req, c22 ? " R7 C22 frame" : " R5/R8 C45 frame"});
    chk(last_period == 4 + 2*dv, {req, " R3 MDC period"}, 64'(last_period), 64'(4 + 2*dv));
    d_exp = rd ? pv : wd;
    reg_rd(2'd1, v);
    chk(v == {9'd0, 1'b0, dv, skip, cmd, d_exp}, {req, " R9/R2 cmd-data readback"}, 64'(v), 64'({9'd0, 1'b0, dv, skip, cmd, d_exp}));
    a_exp = a;
    if (cmd == 2'd2 && !c22) a_exp[15:0] = a[15:0] + 16'd1;
    reg_rd(2'd0, v);
    chk(v == {6'd0, a_exp}, {req, " R10 address after"}, 64'(v), 64'({6'd0, a_exp}));
  endtask

  initial begin
    #(8*190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rises;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      reg_rd(2'(s), v);
      chk(v == 32'd0, "R1 register reset", 64'(v), 64'd0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1/R13 pins after reset", {62'd0, mdc, mdio_oe}, 64'd0);

    txn(26'h2A5_1234, 4'h0, 2'd1, 1'b0, 3'd0, 16'hBEEF, 16'h0, "R5 C45 write");
    txn(26'h1C3_0042, 4'h0, 2'd3, 1'b1, 3'd1, 16'h0000, 16'hA5C3, "R6/R9 C45 read skip");
    txn(26'h3E1_FFFF, 4'h0, 2'd2, 1'b0, 3'd2, 16'h0000, 16'h8001, "R10 read-inc wrap");
    txn(26'h002_0015, 4'h4, 2'd3, 1'b0, 3'd3, 16'h0000, 16'h5A69, "R7/R9 C22 read");
    txn(26'h003_001F, 4'h8, 2'd1, 1'b1, 3'd0, 16'h1357, 16'h0, "R7 C22 write");
    txn(26'h004_0007, 4'hF, 2'd2, 1'b0, 3'd2, 16'h0000, 16'hFFFE, "R8 C22 read-inc");
    txn(26'h0A5_0010, 4'hF, 2'd3, 1'b1, 3'd4, 16'h0000, 16'h0F0F, "R8 port 5 uses C45");
    txn(26'h061_0010, 4'hD, 2'd1, 1'b1, 3'd7, 16'h7777, 16'h0, "R8 unselected port 1");

    // R11 writes during busy are ignored
    reg_wr(2'd2, 32'd0);
    reg_wr(2'd0, 32'h0111_2222);
    @(negedge clk); nrec = 0;
    reg_wr(2'd1, {9'd0, 1'b1, 3'd7, 1'b1, 2'd1, 16'hC0DE});
    repeat (40) @(negedge clk);
    reg_wr(2'd0, 32'h03FF_FFFF);
    reg_wr(2'd2, 32'hF);
    reg_wr(2'd1, {9'd0, 1'b1, 3'd0, 1'b0, 2'd3, 16'h0});
    wait_idle();
    reg_rd(2'd0, v);
    chk(v == 32'h0111_2222, "R11 address write ignored", 64'(v), 64'h0111_2222);
    reg_rd(2'd2, v);
    chk(v == 32'd0, "R11 port write ignored", 64'(v), 64'd0);
    reg_rd(2'd1, v);
    chk(v == {9'd0, 1'b0, 3'd7, 1'b1, 2'd1, 16'hC0DE}, "R11 cmd write ignored", 64'(v), 64'({9'd0, 1'b0, 3'd7, 1'b1, 2'd1, 16'hC0DE}));
    chk(nrec == 64, "R11 no restart", 64'(nrec), 64'd64);

    // R12 command 0
    @(negedge clk); rises = nrec;
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = {9'd0, 1'b1, 3'd2, 1'b0, 2'd0, 16'h1111};
    @(negedge clk); wr_en = 1'b0; rd_sel = 2'd1; #1 v = rd_data;
    chk(v[22] == 1'b1, "R12/R2 busy set after start", 64'(v[22]), 64'd1);
    @(negedge clk); #1 v = rd_data;
    chk(v[22] == 1'b0 && nrec == rises && !mdc, "R12 cmd 0 no frame", 64'(v[22]), 64'd0);

    for (int n = 0; n < 24; n++) begin
      logic [25:0] a;
      logic [1:0] c;
      a = 26'($urandom);
      if ($urandom_range(0, 1) == 1) a[20:16] = 5'($urandom_range(0, 7));
      c = 2'($urandom_range(1, 3));
      txn(a, 4'($urandom), c, 1'($urandom), 3'($urandom), 16'($urandom), 16'($urandom), "R3/R5/R7/R9 random");
    end

    chk(r4_viol == 0, "R4 MDIO stable while MDC high", 64'(r4_viol), 64'd0);
    chk(!mdc && !mdio_oe, "R13 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule